// File: doc/BRIEF.md
# Prioritised Interrupt Entry Sequencer

This block sits next to a small 8-bit processor core and handles the hardware side of entering an interrupt. Peripheral events arrive as single-cycle set pulses on a 64-line vector and are latched into a pending register. The core supplies its global interrupt-enable flag, a flag saying that it is about to skip its next instruction, a reset request, its word program counter and its stack pointer.

When the core can accept an interrupt, the block chooses what to service. A reset request comes first. Otherwise the lowest-numbered pending line is chosen. The block then writes the return address to the byte-wide stack in data memory, one byte per cycle. Next it produces the new program counter at the vector slot, together with a one-cycle request to clear the core's global enable. Only the serviced pending bit is removed, so the remaining lines keep the request active.

The program-counter width and the support for two-word jump slots are elaboration parameters. The PC width sets how many return bytes are pushed. The slot size sets the spacing between vectors.

Top module: `irq_entry_seq`

## Requirements
- R1: While `skip_i` is high, neither a reset request nor a pending interrupt is accepted, and `busy_o` stays low.
- R2: While `gie_i` is low, neither a reset request nor a pending interrupt is accepted, and the pending register is left unchanged.
- R3: A reset request accepted while interrupts are also pending takes precedence. It uses vector 0, so `pc_new_o` is 0, and it leaves the pending register unchanged.
- R4: Among pending lines, the one with the lowest bit index is serviced. All 64 indices work, including indices above 33 and index 63.
- R5: An interrupt on bit index i uses vector number i+1. `pc_new_o` equals the vector number times the slot size: 2 words when LONG_SLOT=1 (the default), and 1 word otherwise.
- R6: The return PC is written one byte per cycle with `mem_we_o` high, least significant byte first. The first byte goes to address `sp_i`, and each following byte goes to the address one lower. Three bytes are pushed when PC_W>16, two when PC_W>8, and one otherwise. The third byte is the PC bits above 15, zero-padded.
- R7: In the cycle where `pc_load_o` is high, `sp_o` equals the captured stack pointer minus the number of bytes pushed.
- R8: `busy_o` goes high in the cycle after acceptance and stays high through the single `pc_load_o` cycle. `gie_clr_o` is high in exactly that cycle. Exactly one load follows the last push.
- R9: Servicing an interrupt clears only the chosen pending bit. `irq_req_o` stays high while any other bit remains pending.
- R10: A high bit on `src_set_i` sets the matching bit of `pend_o` on the next clock edge. The bit then stays set until it is serviced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_set_i | input | SRC_N | Per-line pending set pulses |
| rst_req_i | input | 1 | Reset vector request |
| gie_i | input | 1 | Global interrupt enable from the core |
| skip_i | input | 1 | Core will skip its next instruction |
| pc_i | input | PC_W | Current word program counter (return address) |
| sp_i | input | SP_W | Current stack pointer |
| pend_o | output | SRC_N | Pending register |
| irq_req_o | output | 1 | Any line pending |
| busy_o | output | 1 | Entry sequence in progress |
| mem_we_o | output | 1 | Stack byte write strobe |
| mem_addr_o | output | SP_W | Stack byte write address |
| mem_data_o | output | 8 | Stack byte write data |
| sp_o | output | SP_W | Updated stack pointer |
| pc_load_o | output | 1 | Load `pc_new_o` into the core |
| pc_new_o | output | PC_W | Vector target address |
| gie_clr_o | output | 1 | Clear the core's global enable |

## Verification
The hardest case to reach is a reset request that arrives while several interrupt lines are already pending and the enable flag is set. To build it, the bench first latches lines with the enable held low. It also holds the skip flag high with the enable raised, so that a premature acceptance would be visible. It then raises the reset request for exactly the one acceptance cycle and drops the enable straight afterwards. High indices such as 34, 40 and 63 are placed next to lower ones, so that an encoder that only looks at the lower bits would give a wrong vector.

// File: rtl/irq_seq_pkg.sv
// Package: shared types and helpers for the interrupt entry sequencer.
// Assumes: PC widths up to 24 bits.
package irq_seq_pkg;

    // Sequencer states: waiting, pushing return bytes, loading the vector PC.
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_PUSH = 2'd1,
        ST_LOAD = 2'd2
    } seq_state_e;

    // Number of return-address bytes pushed for a given PC width.
    function automatic int push_bytes(input int pc_w);
        if (pc_w > 16) return 3;
        else if (pc_w > 8) return 2;
        return 1;
    endfunction

endpackage

// File: rtl/irq_pend_store.sv
// Module: holds the pending interrupt bits.
// Set pulses are ORed in; the clear mask removes serviced bits.
// Assumes: the clear mask has at most one bit set.
// A set and a clear on the same bit in the same cycle leave the bit set.
module irq_pend_store #(
    parameter int SRC_N = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SRC_N-1:0] set_i,
    input  logic [SRC_N-1:0] clr_i,
    output logic [SRC_N-1:0] pend_o
);

    logic [SRC_N-1:0] pend_q;

    // Update the pending register: clear the serviced bit, then add new events.
    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= (pend_q & ~clr_i) | set_i;
    end

    assign pend_o = pend_q;

    // R9: at most one pending bit is ever cleared per service.
    a_r9_single_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (|clr_i) |-> ($countones(clr_i) == 1 && (pend_q & clr_i) != '0));

    // R9: a bit that is neither cleared nor set keeps its value.
    a_r9_others_kept: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((pend_q & ~$past(clr_i)) == ($past(pend_q) & ~$past(clr_i)))
                 || ($past(set_i) != '0));

endmodule

// File: rtl/irq_prio_pick.sv
// Module: lowest-index-wins priority encoder over the pending vector.
// Assumes: SRC_N is a power of two, so the index fits IDX_W bits.
module irq_prio_pick #(
    parameter int SRC_N = 64,
    parameter int IDX_W = $clog2(SRC_N)
) (
    input  logic [SRC_N-1:0] pend_i,
    output logic             valid_o,
    output logic [IDX_W-1:0] idx_o
);

    // Scan from the top so the lowest set bit is the last one written.
    always_comb begin
        idx_o = '0;
        for (int i = SRC_N - 1; i >= 0; i--) begin
            if (pend_i[i]) idx_o = IDX_W'(i);
        end
    end

    // Any request present.
    assign valid_o = |pend_i;

endmodule

// File: rtl/irq_push_fsm.sv
// Module: entry sequencer FSM.
// It decides acceptance, pushes the return PC one byte per cycle and then
// presents the vector PC together with a global-enable clear.
// Assumes: the core lowers gie_i after the load cycle, before the next acceptance.
module irq_push_fsm
    import irq_seq_pkg::*;
#(
    parameter int PC_W      = 22,
    parameter int SP_W      = 16,
    parameter int IDX_W     = 6,
    parameter bit LONG_SLOT = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             skip_i,
    input  logic             gie_i,
    input  logic             rst_req_i,
    input  logic             irq_valid_i,
    input  logic [IDX_W-1:0] irq_idx_i,
    input  logic [PC_W-1:0]  pc_i,
    input  logic [SP_W-1:0]  sp_i,
    output logic             take_irq_o,
    output logic             busy_o,
    output logic             mem_we_o,
    output logic [SP_W-1:0]  mem_addr_o,
    output logic [7:0]       mem_data_o,
    output logic [SP_W-1:0]  sp_o,
    output logic             pc_load_o,
    output logic [PC_W-1:0]  pc_new_o,
    output logic             gie_clr_o
);

    localparam int NB      = push_bytes(PC_W);
    localparam int RET_W   = 8 * NB;
    localparam int VEC_W   = IDX_W + 1;
    localparam int SLOT_SH = LONG_SLOT ? 1 : 0;

    seq_state_e       state_q;
    logic [1:0]       cnt_q;
    logic [RET_W-1:0] ret_q;
    logic [SP_W-1:0]  sp_q;
    logic [VEC_W-1:0] vec_q;
    logic             accept;

    // Acceptance: idle, no pending skip, enable set, and something to serve.
    assign accept     = (state_q == ST_IDLE) && !skip_i && gie_i && (rst_req_i || irq_valid_i);
    assign take_irq_o = accept && !rst_req_i;

    // State, byte counter and captured context.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            ret_q   <= '0;
            sp_q    <= '0;
            vec_q   <= '0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (accept) begin
                        state_q <= ST_PUSH;
                        cnt_q   <= '0;
                        ret_q   <= RET_W'(pc_i);
                        sp_q    <= sp_i;
                        vec_q   <= rst_req_i ? '0 : VEC_W'(irq_idx_i) + VEC_W'(1);
                    end
                end
                ST_PUSH: begin
                    sp_q  <= sp_q - SP_W'(1);
                    cnt_q <= cnt_q + 2'd1;
                    if (cnt_q == 2'(NB - 1)) state_q <= ST_LOAD;
                end
                ST_LOAD: state_q <= ST_IDLE;
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Output decode from the state and the captured context.
    assign busy_o     = (state_q != ST_IDLE);
    assign mem_we_o   = (state_q == ST_PUSH);
    assign mem_addr_o = sp_q;
    assign mem_data_o = 8'(ret_q >> (cnt_q * 8));
    assign sp_o       = sp_q;
    assign pc_load_o  = (state_q == ST_LOAD);
    assign gie_clr_o  = (state_q == ST_LOAD);
    assign pc_new_o   = PC_W'(vec_q) << SLOT_SH;

    // R1: a pending skip holds off entry.
    a_r1_skip_holds_off: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && skip_i) |=> !busy_o);

    // R2: a cleared global enable holds off entry.
    a_r2_gie_holds_off: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !gie_i) |=> !busy_o);

    // R6: consecutive stack writes step down by one address.
    a_r6_addr_descends: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we_o && $past(mem_we_o)) |-> (mem_addr_o == $past(mem_addr_o) - SP_W'(1)));

    // R8: the push burst is followed directly by the load cycle.
    a_r8_push_then_load: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_we_o) |-> pc_load_o);

    // R8: the load cycle ends the sequence.
    a_r8_load_ends: assert property (@(posedge clk) disable iff (!rst_n)
        pc_load_o |=> !busy_o);

endmodule

// File: rtl/irq_entry_seq.sv
// Module: top of the interrupt entry sequencer.
// It joins the pending store, the priority picker and the push FSM, and it
// turns an accepted interrupt into a one-hot clear of its pending bit.
// Assumes: synchronous active-low reset, single clock.
module irq_entry_seq #(
    parameter int SRC_N     = 64,
    parameter int PC_W      = 22,
    parameter int SP_W      = 16,
    parameter bit LONG_SLOT = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SRC_N-1:0] src_set_i,
    input  logic             rst_req_i,
    input  logic             gie_i,
    input  logic             skip_i,
    input  logic [PC_W-1:0]  pc_i,
    input  logic [SP_W-1:0]  sp_i,
    output logic [SRC_N-1:0] pend_o,
    output logic             irq_req_o,
    output logic             busy_o,
    output logic             mem_we_o,
    output logic [SP_W-1:0]  mem_addr_o,
    output logic [7:0]       mem_data_o,
    output logic [SP_W-1:0]  sp_o,
    output logic             pc_load_o,
    output logic [PC_W-1:0]  pc_new_o,
    output logic             gie_clr_o
);

    localparam int IDX_W = $clog2(SRC_N);

    logic [SRC_N-1:0] pend;
    logic [SRC_N-1:0] clr_mask;
    logic             pick_valid;
    logic [IDX_W-1:0] pick_idx;
    logic             take_irq;

    irq_pend_store #(.SRC_N(SRC_N)) u_store (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (src_set_i),
        .clr_i  (clr_mask),
        .pend_o (pend)
    );

    irq_prio_pick #(.SRC_N(SRC_N), .IDX_W(IDX_W)) u_pick (
        .pend_i  (pend),
        .valid_o (pick_valid),
        .idx_o   (pick_idx)
    );

    irq_push_fsm #(
        .PC_W      (PC_W),
        .SP_W      (SP_W),
        .IDX_W     (IDX_W),
        .LONG_SLOT (LONG_SLOT)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .skip_i      (skip_i),
        .gie_i       (gie_i),
        .rst_req_i   (rst_req_i),
        .irq_valid_i (pick_valid),
        .irq_idx_i   (pick_idx),
        .pc_i        (pc_i),
        .sp_i        (sp_i),
        .take_irq_o  (take_irq),
        .busy_o      (busy_o),
        .mem_we_o    (mem_we_o),
        .mem_addr_o  (mem_addr_o),
        .mem_data_o  (mem_data_o),
        .sp_o        (sp_o),
        .pc_load_o   (pc_load_o),
        .pc_new_o    (pc_new_o),
        .gie_clr_o   (gie_clr_o)
    );

    // One-hot clear of the serviced line; a reset entry clears nothing.
    always_comb begin
        clr_mask = '0;
        if (take_irq) clr_mask[pick_idx] = 1'b1;
    end

    assign pend_o    = pend;
    assign irq_req_o = |pend;

    // R4: the chosen line is pending and no lower line is.
    a_r4_lowest_wins: assert property (@(posedge clk) disable iff (!rst_n)
        pick_valid |-> (pend[pick_idx] &&
            ((pend & ((SRC_N'(1) << pick_idx) - SRC_N'(1))) == '0)));

    // R3: a reset entry never removes a pending bit.
    a_r3_reset_keeps_pending: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_req_i && gie_i && !skip_i && !busy_o) |-> (clr_mask == '0));

endmodule

// File: tb/irq_entry_seq_bench.sv
// Scoreboard bench for irq_entry_seq with default parameters.
module irq_entry_seq_bench;

    localparam int SRC_N = 64;
    localparam int PC_W  = 22;
    localparam int SP_W  = 16;
    localparam int NB    = (PC_W > 16) ? 3 : ((PC_W > 8) ? 2 : 1);

    typedef struct {
        bit          is_load;
        logic [23:0] val;
        logic [15:0] addr;
        string       tag;
    } exp_t;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [SRC_N-1:0] src_set_i = '0;
    logic             rst_req_i = 1'b0;
    logic             gie_i = 1'b0;
    logic             skip_i = 1'b0;
    logic [PC_W-1:0]  pc_i = '0;
    logic [SP_W-1:0]  sp_i = '0;
    logic [SRC_N-1:0] pend_o;
    logic             irq_req_o, busy_o, mem_we_o, pc_load_o, gie_clr_o;
    logic [SP_W-1:0]  mem_addr_o, sp_o;
    logic [7:0]       mem_data_o;
    logic [PC_W-1:0]  pc_new_o;

    int   checks = 0;
    int   fails  = 0;
    bit   done   = 1'b0;
    exp_t expq[$];
    logic [SRC_N-1:0] model_pend = '0;

    irq_entry_seq u_irq_entry_seq (
        .clk(clk), .rst_n(rst_n), .src_set_i(src_set_i), .rst_req_i(rst_req_i),
        .gie_i(gie_i), .skip_i(skip_i), .pc_i(pc_i), .sp_i(sp_i),
        .pend_o(pend_o), .irq_req_o(irq_req_o), .busy_o(busy_o),
        .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o), .mem_data_o(mem_data_o),
        .sp_o(sp_o), .pc_load_o(pc_load_o), .pc_new_o(pc_new_o), .gie_clr_o(gie_clr_o)
    );

    always #4 clk = ~clk;

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Monitor: pop and compare each write or load the design produces.
    always @(negedge clk) begin
        if (rst_n && (mem_we_o || pc_load_o)) begin
            if (expq.size() == 0) begin
                chk(1'b0, "R8 unexpected output event", {62'd0, mem_we_o, pc_load_o}, 64'd0);
            end else begin
                exp_t e;
                e = expq.pop_front();
                if (e.is_load) begin
                    chk(pc_load_o && !mem_we_o, {e.tag, " R8 load expected"}, {63'd0, pc_load_o}, 64'd1);
                    chk(pc_new_o == e.val[PC_W-1:0], {e.tag, " R5 vector pc"}, 64'(pc_new_o), 64'(e.val));
                    chk(sp_o == e.addr, {e.tag, " R7 final sp"}, 64'(sp_o), 64'(e.addr));
                    chk(gie_clr_o == 1'b1, {e.tag, " R8 gie clear"}, 64'(gie_clr_o), 64'd1);
                end else begin
                    chk(mem_we_o && !pc_load_o, {e.tag, " R6 write expected"}, {63'd0, mem_we_o}, 64'd1);
                    chk(mem_addr_o == e.addr, {e.tag, " R6 push addr"}, 64'(mem_addr_o), 64'(e.addr));
                    chk(mem_data_o == e.val[7:0], {e.tag, " R6 push byte"}, 64'(mem_data_o), 64'(e.val[7:0]));
                end
            end
        end
    end

    // Driver: raise set pulses for one cycle.
    task automatic raise(input logic [SRC_N-1:0] bits);
        @(negedge clk);
        src_set_i = bits;
        @(negedge clk);
        src_set_i = '0;
        model_pend = model_pend | bits;
    endtask

    // Driver: one accepted entry; queues the expected pushes and load.
    task automatic service(input logic [PC_W-1:0] pc, input logic [SP_W-1:0] sp,
                           input bit is_reset, input int vec, input string tag);
        exp_t e;
        @(negedge clk);
        pc_i = pc;
        sp_i = sp;
        for (int k = 0; k < NB; k++) begin
            e.is_load = 1'b0;
            e.addr    = sp - 16'(k);
            e.val     = 24'((24'(pc) >> (8 * k)) & 24'hFF);
            e.tag     = tag;
            expq.push_back(e);
        end
        e.is_load = 1'b1;
        e.val     = 24'(vec * 2);
        e.addr    = sp - 16'(NB);
        e.tag     = tag;
        expq.push_back(e);
        gie_i     = 1'b1;
        rst_req_i = is_reset;
        @(negedge clk);
        gie_i     = 1'b0;
        rst_req_i = 1'b0;
        chk(busy_o == 1'b1, {tag, " R8 busy after accept"}, 64'(busy_o), 64'd1);
        repeat (NB + 2) @(negedge clk);
        chk(expq.size() == 0, {tag, " R6 all events seen"}, 64'(expq.size()), 64'd0);
        chk(busy_o == 1'b0, {tag, " R8 idle after load"}, 64'(busy_o), 64'd0);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(busy_o == 1'b0 && mem_we_o == 1'b0 && pc_load_o == 1'b0, "reset outputs idle", 64'(busy_o), 64'd0);
        chk(pend_o == '0 && irq_req_o == 1'b0, "reset pending empty", pend_o, 64'd0);

        // R10: latch lines 40 and 63 with enable low.
        raise((64'd1 << 40) | (64'd1 << 63));
        chk(pend_o == model_pend, "R10 pending latched", pend_o, model_pend);

        // R2: enable low blocks acceptance.
        repeat (3) begin
            @(negedge clk);
            chk(busy_o == 1'b0, "R2 no entry with enable low", 64'(busy_o), 64'd0);
        end

        // R1: skip pending blocks both reset and interrupts.
        @(negedge clk);
        skip_i = 1'b1; gie_i = 1'b1; rst_req_i = 1'b1;
        repeat (3) begin
            @(negedge clk);
            chk(busy_o == 1'b0 && mem_we_o == 1'b0, "R1 no entry while skip", 64'(busy_o), 64'd0);
        end
        gie_i = 1'b0; rst_req_i = 1'b0; skip_i = 1'b0;
        @(negedge clk);
        chk(pend_o == model_pend, "R1 pending untouched", pend_o, model_pend);

        // R4/R5/R9: line 40 beats 63, vector 41.
        service(22'h2A5C3E, 16'h08FF, 1'b0, 41, "R4 idx40");
        model_pend[40] = 1'b0;
        chk(pend_o == model_pend, "R9 only bit 40 cleared", pend_o, model_pend);
        chk(irq_req_o == 1'b1, "R9 request held", 64'(irq_req_o), 64'd1);

        // R4: add lines 0 and 5; line 0 wins, vector 1.
        raise((64'd1 << 0) | (64'd1 << 5));
        service(22'h00_1234, 16'h0400, 1'b0, 1, "R5 idx0");
        model_pend[0] = 1'b0;
        chk(pend_o == model_pend, "R9 only bit 0 cleared", pend_o, model_pend);

        // R3: reset request wins over pending lines; pending unchanged.
        service(22'h3FFFFF, 16'h0010, 1'b1, 0, "R3 reset");
        chk(pend_o == model_pend, "R3 pending unchanged", pend_o, model_pend);

        // R2: reset request with enable low is ignored.
        @(negedge clk);
        rst_req_i = 1'b1;
        repeat (2) begin
            @(negedge clk);
            chk(busy_o == 1'b0, "R2 reset blocked by enable low", 64'(busy_o), 64'd0);
        end
        rst_req_i = 1'b0;

        // R4: indices above 33.
        service(22'h01_0203, 16'h0200, 1'b0, 6, "R4 idx5");
        model_pend[5] = 1'b0;
        raise((64'd1 << 35) | (64'd1 << 34));
        service(22'h15_AA55, 16'hFFFF, 1'b0, 35, "R4 idx34");
        model_pend[34] = 1'b0;
        service(22'h00_00FF, 16'h1000, 1'b0, 36, "R4 idx35");
        model_pend[35] = 1'b0;
        service(22'h2F_0001, 16'h0003, 1'b0, 64, "R4 idx63");
        model_pend[63] = 1'b0;
        chk(pend_o == '0, "R9 all serviced", pend_o, 64'd0);
        chk(irq_req_o == 1'b0, "R9 request drops", 64'(irq_req_o), 64'd0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule